// File: doc/BRIEF.md
# Bus-Idle Sleep and Wake Controller

This block sets the power mode of a small I/O node attached to a CAN bus. In normal operation it counts bit-time ticks while the bus is quiet. When sleep is enabled and the quiet period reaches a fixed number of consecutive bit times, the node goes to sleep. Any bus activity restarts the count. A second configuration starts the node in listen-only mode after reset. If the bus is quiet on the first cycle after reset, the node sleeps straight away. After it wakes, it stays in listen-only mode until it sees one valid message, and only then moves to normal mode.

Three events end sleep: the external reset-wake input, an edge on a GPIO pin whose own interrupt enable is set, and bus activity. When the controller wakes, it raises a one-cycle request to the oscillator start-up sequencer. It then stays in a waking state until that sequencer reports done. While the node is asleep or waking, a gate output holds the peripherals off: conversions, automatic messaging, PWM and the clock output. The pins keep their previous drive because nothing updates them. When bus activity causes the wake, a suppress flag stops the wake frame from being received or acknowledged. The flag clears once the bus goes idle again.

Top module: `bus_sleep_ctrl`

## Requirements
- R1: While `rst` is high with `pu_sleep_en` low, the controller is in normal mode: `op_normal`=1, `sleeping`=0, `periph_gate`=0, `ost_req`=0, `rx_suppress`=0.
- R2: In normal mode with `sleep_en`=1, `sleeping` rises on the clock edge that samples the IDLE_BITS-th consecutive tick with `bus_active` low (IDLE_BITS defaults to 1408). After IDLE_BITS-1 such ticks it is still low.
- R3: A cycle with `bus_active` high restarts the idle count from zero. With `sleep_en`=0 the node never sleeps from normal mode.
- R4: If reset is released with `pu_sleep_en`=1, the node sleeps on the first edge after reset when `bus_active` is low. If `bus_active` is high on that edge, the node stays awake in listen-only mode (`op_normal`=0, `sleeping`=0).
- R5: While asleep, any of these wakes the node on the next edge: `ext_wake` high, `bus_active` high, or `gpio_edge[i]` and `gpio_ie[i]` both high for some pin i. A GPIO edge whose enable bit is 0 has no effect.
- R6: On a wake, `ost_req` is high for exactly the one cycle after the wake event. The node then stays waking (`sleeping`=0, `op_normal`=0) until `ost_done` is sampled high.
- R7: After `ost_done`, the node returns to normal mode. If the sleep was the power-up listen-only sleep, it returns to listen-only mode instead, and moves to normal mode on the first `msg_valid` sampled while `rx_suppress` is 0.
- R8: A wake caused by `bus_active` sets `rx_suppress`. A wake from a GPIO edge or `ext_wake` alone does not set it. While it is set, `msg_valid` is ignored. It clears on the edge after `bus_active` is sampled low.
- R9: `periph_gate` is high while sleeping or waking, and low in normal and listen-only modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per CAN bit time |
| bus_active | input | 1 | High while the bus is not idle |
| sleep_en | input | 1 | Allow idle-timed sleep in normal mode |
| pu_sleep_en | input | 1 | Start in listen-only mode with immediate sleep after reset |
| gpio_edge | input | GPIO_W | Per-pin edge-detected events |
| gpio_ie | input | GPIO_W | Per-pin wake/interrupt enables |
| ext_wake | input | 1 | External reset-pin wake request |
| msg_valid | input | 1 | Strobe: a valid message was received |
| ost_done | input | 1 | Oscillator start-up sequence finished |
| sleeping | output | 1 | Node is in the sleep state |
| periph_gate | output | 1 | Holds peripherals off |
| ost_req | output | 1 | One-cycle start-up sequencer request |
| rx_suppress | output | 1 | Blocks reception of the wake frame |
| op_normal | output | 1 | Node is in normal mode |

## Verification
Every pairing of GPIO edge pattern and enable mask is applied from sleep in a small configuration. This shows that only a pin with both bits set wakes the node, and that such a wake never sets `rx_suppress`. The idle count is probed one tick short of the limit and exactly at it, both after a clean start and after a burst of bus activity. This separates a missing restart from an off-by-one error. Both power-up paths (quiet bus and busy bus) are run. In them, `msg_valid` arrives while suppression is still set and again after it clears, which shows that the wake frame cannot confirm the listen-only exit.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        PM_BOOT_LISTEN,
        PM_LISTEN,
        PM_NORMAL,
        PM_SLEEP,
        PM_WAKE
    } pm_state_e;

    typedef struct packed {
        logic any;
        logic by_bus;
    } wake_ev_t;

    function automatic logic pin_wakes(input logic edge_seen, input logic enabled);
        return edge_seen & enabled;
    endfunction

endpackage

// File: rtl/bsc_idle_timer.sv
module bsc_idle_timer #(
    parameter int IDLE_BITS = 1408
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_tick,
    input  logic bus_active,
    output logic expire
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || bus_active)
            cnt <= '0;
        else if (bit_tick && cnt != CW'(IDLE_BITS))
            cnt <= cnt + 1'b1;
    end

    assign expire = run & bit_tick & ~bus_active & (cnt == LAST);

    // R3: bus activity restarts the quiet count
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        (run && bus_active) |=> (cnt == '0));

    // R2: count never runs past the limit
    a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(IDLE_BITS));

endmodule

// File: rtl/bsc_wake_detect.sv
module bsc_wake_detect
    import bsc_pkg::*;
#(
    parameter int GPIO_W = 4
) (
    input  logic [GPIO_W-1:0] gpio_edge,
    input  logic [GPIO_W-1:0] gpio_ie,
    input  logic              ext_wake,
    input  logic              bus_active,
    output wake_ev_t          ev
);
    logic [GPIO_W-1:0] pin_hit;

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        assign pin_hit[i] = pin_wakes(gpio_edge[i], gpio_ie[i]);
    end

    always_comb begin
        ev.by_bus = bus_active;
        ev.any    = bus_active | ext_wake | (|pin_hit);
    end

endmodule

// File: rtl/bus_sleep_ctrl.sv
module bus_sleep_ctrl
    import bsc_pkg::*;
#(
    parameter int IDLE_BITS = 1408,
    parameter int GPIO_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              bus_active,
    input  logic              sleep_en,
    input  logic              pu_sleep_en,
    input  logic [GPIO_W-1:0] gpio_edge,
    input  logic [GPIO_W-1:0] gpio_ie,
    input  logic              ext_wake,
    input  logic              msg_valid,
    input  logic              ost_done,
    output logic              sleeping,
    output logic              periph_gate,
    output logic              ost_req,
    output logic              rx_suppress,
    output logic              op_normal
);
    pm_state_e state, state_nx;
    wake_ev_t  wev;
    logic      expire;
    logic      pu_path;
    logic      msg_ok;

    bsc_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (state == PM_NORMAL && sleep_en),
        .bit_tick   (bit_tick),
        .bus_active (bus_active),
        .expire     (expire)
    );

    bsc_wake_detect #(.GPIO_W(GPIO_W)) u_wake (
        .gpio_edge  (gpio_edge),
        .gpio_ie    (gpio_ie),
        .ext_wake   (ext_wake),
        .bus_active (bus_active),
        .ev         (wev)
    );

    assign msg_ok = msg_valid & ~rx_suppress;

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_BOOT_LISTEN: state_nx = bus_active ? PM_LISTEN : PM_SLEEP;
            PM_LISTEN:      if (msg_ok) state_nx = PM_NORMAL;
            PM_NORMAL:      if (expire) state_nx = PM_SLEEP;
            PM_SLEEP:       if (wev.any) state_nx = PM_WAKE;
            PM_WAKE:        if (ost_done) state_nx = pu_path ? PM_LISTEN : PM_NORMAL;
            default:        state_nx = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= pu_sleep_en ? PM_BOOT_LISTEN : PM_NORMAL;
            pu_path     <= 1'b0;
            ost_req     <= 1'b0;
            rx_suppress <= 1'b0;
        end else begin
            state   <= state_nx;
            ost_req <= (state == PM_SLEEP) && wev.any;
            if (state == PM_BOOT_LISTEN && !bus_active)
                pu_path <= 1'b1;
            else if (state_nx == PM_NORMAL)
                pu_path <= 1'b0;
            if (state == PM_SLEEP && wev.by_bus)
                rx_suppress <= 1'b1;
            else if (!bus_active)
                rx_suppress <= 1'b0;
        end
    end

    assign sleeping    = (state == PM_SLEEP);
    assign periph_gate = (state == PM_SLEEP) || (state == PM_WAKE);
    assign op_normal   = (state == PM_NORMAL);

    // R6: start-up request lasts one cycle
    a_r6_ost_single: assert property (@(posedge clk) disable iff (rst)
        ost_req |=> !ost_req);

    // R5: a detected wake event leaves sleep and requests start-up
    a_r5_wake_reacts: assert property (@(posedge clk) disable iff (rst)
        (state == PM_SLEEP && wev.any) |=> (state == PM_WAKE && ost_req));

    // R6: waking holds until start-up done
    a_r6_hold_wake: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WAKE && !ost_done) |=> (state == PM_WAKE));

    // R7: listen-only exits only on an accepted message
    a_r7_listen_gate: assert property (@(posedge clk) disable iff (rst)
        (state == PM_LISTEN && !(msg_valid && !rx_suppress)) |=> (state != PM_NORMAL));

    // R8: suppression only comes from bus activity
    a_r8_sup_source: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_suppress) |-> $past(bus_active));

endmodule

// File: tb/bus_sleep_ctrl_test.sv
module bus_sleep_ctrl_test;
    localparam int IB = 24;
    localparam int GW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 0, bus_active = 0, sleep_en = 0, pu_sleep_en = 0;
    logic [GW-1:0] gpio_edge = '0, gpio_ie = '0;
    logic ext_wake = 0, msg_valid = 0, ost_done = 0;
    logic sleeping, periph_gate, ost_req, rx_suppress, op_normal;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_sleep_ctrl #(.IDLE_BITS(IB), .GPIO_W(GW)) uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_active(bus_active),
        .sleep_en(sleep_en), .pu_sleep_en(pu_sleep_en), .gpio_edge(gpio_edge),
        .gpio_ie(gpio_ie), .ext_wake(ext_wake), .msg_valid(msg_valid),
        .ost_done(ost_done), .sleeping(sleeping), .periph_gate(periph_gate),
        .ost_req(ost_req), .rx_suppress(rx_suppress), .op_normal(op_normal)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_sleep();
        bit_tick = 1;
        step(IB);
        bit_tick = 0;
        chk("R2 re-sleep", int'(sleeping), 1);
    endtask

    task automatic finish_wake();
        ost_done = 1;
        step();
        ost_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        chk("R1 op_normal", int'(op_normal), 1);
        chk("R1 sleeping", int'(sleeping), 0);
        chk("R1 gate", int'(periph_gate), 0);
        chk("R1 ost_req", int'(ost_req), 0);
        chk("R1 rx_suppress", int'(rx_suppress), 0);
        rst = 0;

        // R2: limit minus one, then exactly the limit
        sleep_en = 1;
        bit_tick = 1;
        step(IB - 1);
        chk("R2 not yet", int'(sleeping), 0);
        step();
        chk("R2 asleep", int'(sleeping), 1);
        chk("R9 gate asleep", int'(periph_gate), 1);
        bit_tick = 0;

        // R5/R8/R6: sweep all edge/enable pairs
        for (int e = 0; e < 16; e++) begin
            for (int m = 0; m < 16; m++) begin
                automatic int woke = ((e & m) != 0) ? 1 : 0;
                gpio_edge = GW'(e);
                gpio_ie = GW'(m);
                step();
                gpio_edge = '0;
                chk("R5 gpio sweep", int'(sleeping), 1 - woke);
                chk("R6 ost pulse", int'(ost_req), woke);
                if (woke == 1) begin
                    chk("R8 gpio no suppress", int'(rx_suppress), 0);
                    step();
                    chk("R6 ost one cycle", int'(ost_req), 0);
                    chk("R6 waking", int'(sleeping) + int'(op_normal), 0);
                    chk("R9 gate waking", int'(periph_gate), 1);
                    finish_wake();
                    chk("R7 back normal", int'(op_normal), 1);
                    chk("R9 gate normal", int'(periph_gate), 0);
                    go_sleep();
                end
            end
        end
        gpio_ie = '0;

        // R5: external wake
        ext_wake = 1;
        step();
        ext_wake = 0;
        chk("R5 ext wake", int'(sleeping), 0);
        chk("R8 ext no suppress", int'(rx_suppress), 0);
        step(3);
        chk("R6 hold waking", int'(op_normal), 0);
        finish_wake();
        chk("R7 ext to normal", int'(op_normal), 1);

        // R3: activity restarts count
        bit_tick = 1;
        step(10);
        bus_active = 1;
        step();
        bus_active = 0;
        step(IB - 1);
        chk("R3 restart not yet", int'(sleeping), 0);
        step();
        chk("R3 restart asleep", int'(sleeping), 1);
        bit_tick = 0;

        // R5/R8: bus wake from normal-path sleep
        bus_active = 1;
        step();
        chk("R5 bus wake", int'(sleeping), 0);
        chk("R8 suppress set", int'(rx_suppress), 1);
        msg_valid = 1;
        step();
        msg_valid = 0;
        chk("R8 still waking", int'(op_normal), 0);
        bus_active = 0;
        step();
        chk("R8 suppress clear", int'(rx_suppress), 0);
        finish_wake();
        chk("R7 bus wake normal", int'(op_normal), 1);

        // R3: sleep disabled
        sleep_en = 0;
        bit_tick = 1;
        step(5 * IB);
        chk("R3 sleep_en off", int'(sleeping), 0);
        bit_tick = 0;

        // R4/R7/R8: power-up sleep on quiet bus
        rst = 1;
        pu_sleep_en = 1;
        step(2);
        chk("R4 listen in reset", int'(op_normal), 0);
        rst = 0;
        step();
        chk("R4 quiet sleep", int'(sleeping), 1);
        bus_active = 1;
        step();
        chk("R8 pu suppress", int'(rx_suppress), 1);
        chk("R6 pu ost", int'(ost_req), 1);
        finish_wake();
        chk("R7 to listen", int'(op_normal) + int'(sleeping), 0);
        chk("R9 listen gate", int'(periph_gate), 0);
        msg_valid = 1;
        step();
        msg_valid = 0;
        chk("R8 wake frame ignored", int'(op_normal), 0);
        bus_active = 0;
        step();
        chk("R8 clear in listen", int'(rx_suppress), 0);
        step(3);
        chk("R7 listen holds", int'(op_normal), 0);
        msg_valid = 1;
        step();
        msg_valid = 0;
        chk("R7 confirm normal", int'(op_normal), 1);

        // R4: power-up with busy bus
        rst = 1;
        step(2);
        bus_active = 1;
        rst = 0;
        step();
        chk("R4 busy no sleep", int'(sleeping), 0);
        chk("R4 busy listen", int'(op_normal), 0);
        bus_active = 0;
        step(2);
        chk("R4 busy stays listen", int'(op_normal) + int'(sleeping), 0);
        msg_valid = 1;
        step();
        msg_valid = 0;
        chk("R7 busy confirm", int'(op_normal), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule